// File: doc/BRIEF.md
# Interleaved DMA address generator

This block turns a compact description of a two-dimensional transfer into a stream of byte addresses for a DMA engine. The transfer is built from one frame. A frame is an ordered list of chunks, and each chunk has a byte length and a gap that follows it. That frame is replayed a programmed number of times. Before a run, software fills a table of up to 16 {length, gap} entries through a write port. It then presents the frame count, the entry count, the direction code, the per-side increment and scatter flags and the two base addresses, and pulses start.

While a run is active, the block offers one {source, destination} byte-address pair per beat on a valid/ready handshake. It marks the final beat, pulses once at the end of every frame, and pulses at the end of the run. The table and the attributes stay loaded, so repeating a transfer only needs new base addresses and another start. The block moves no data. It fetches no descriptors and does not speak any bus protocol.

Top module: `idma_addr_gen`

## Requirements
- R1: After reset, beat_valid, beat_last, busy, frame_done, done and err are all low.
- R2: A table write stores the length and gap at the written index. Entries persist across transfers until rewritten, so a second start with only new base addresses replays the same pattern.
- R3: A side whose increment flag is set and whose scatter flag is clear advances by exactly one byte per accepted beat, chunk boundaries included.
- R4: A side whose increment flag is clear keeps its base address on every beat of the transfer, whatever its scatter flag is.
- R5: A side with both its increment and scatter flags set advances by one plus the current entry's gap after the last byte of each chunk. After the last entry, the pattern wraps to entry 0 of the next frame, and the last entry's gap is still added.
- R6: While beat_valid is high and beat_ready is low, beat_valid, beat_src and beat_dst hold their values.
- R7: beat_last is high only on the final byte of the final entry of the final frame.
- R8: frame_done is a one-cycle pulse in the cycle after each frame's final beat is accepted. done pulses, together with frame_done, in the cycle after the final beat is accepted, and busy falls in that same cycle.
- R9: Direction codes 0 (memory to memory), 1 (memory to device), 2 (device to memory) and 3 (device to device) are accepted. Code 4 (no transfer) and any higher code set err and start nothing.
- R10: A start sets err and produces no beats when any of these holds: the entry count is 0, the entry count is above the table depth, the frame count is 0, or any entry below the entry count has length 0. Entries never written count as length 0.
- R11: A start pulse while busy is high is ignored. The running transfer's addresses continue unchanged.
- R12: err stays high until the next accepted start with a valid configuration, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 4 | Table entry index |
| tbl_len | input | 16 | Chunk length in bytes |
| tbl_gap | input | 16 | Gap in bytes after the chunk |
| cfg_frames | input | 16 | Number of frame repetitions |
| cfg_entries | input | 5 | Entries per frame |
| cfg_dir | input | 3 | Direction code |
| cfg_src_inc | input | 1 | Source address increments |
| cfg_dst_inc | input | 1 | Destination address increments |
| cfg_src_scat | input | 1 | Source honours gaps |
| cfg_dst_scat | input | 1 | Destination honours gaps |
| cfg_src_base | input | 32 | First source address |
| cfg_dst_base | input | 32 | First destination address |
| start | input | 1 | Start pulse |
| beat_ready | input | 1 | Consumer accepts the current beat |
| beat_valid | output | 1 | Address pair is valid |
| beat_src | output | 32 | Source byte address |
| beat_dst | output | 32 | Destination byte address |
| beat_last | output | 1 | Final beat of the transfer |
| frame_done | output | 1 | Frame finished pulse |
| done | output | 1 | Transfer finished pulse |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last start was rejected |

## Verification
The end-of-frame pulse and the end-of-transfer pulse share a cycle on the final frame. Every vector therefore counts frame_done pulses and checks that frame_done is high in the very cycle done appears. A second overlap is a start pulse that arrives mid-run together with altered base addresses. The bench judges it by confirming that the next offered address still matches the model of the running transfer. Ready patterns of always, alternate and one-in-three place chunk ends, frame wraps and stalls on the same beats.

// File: rtl/idma_pkg.sv
package idma_pkg;

  typedef enum logic [2:0] {
    DIR_M2M  = 3'd0,
    DIR_M2D  = 3'd1,
    DIR_D2M  = 3'd2,
    DIR_D2D  = 3'd3,
    DIR_NONE = 3'd4
  } dir_e;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_SRC  = 0;
  localparam int SIDE_DST  = 1;

  function automatic logic dir_is_valid(input logic [2:0] code);
    return code <= DIR_D2D;
  endfunction

endpackage

// File: rtl/idma_chunk_tbl.sv
module idma_chunk_tbl #(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 16,
  parameter int GAP_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [SIZE_W-1:0]        wlen,
  input  logic [GAP_W-1:0]         wgap,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [SIZE_W-1:0]        rlen,
  output logic [GAP_W-1:0]         rgap,
  output logic [DEPTH-1:0]         empty_map
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [SIZE_W-1:0] len_mem [DEPTH];
  logic [GAP_W-1:0]  gap_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      len_mem[waddr] <= wlen;
      gap_mem[waddr] <= wgap;
    end
  end

  assign rlen = len_mem[raddr];
  assign rgap = gap_mem[raddr];

  // one flag per entry: length is zero or never written
  for (genvar i = 0; i < DEPTH; i++) begin : g_empty
    always_ff @(posedge clk) begin
      if (rst)
        empty_map[i] <= 1'b1;
      else if (we && waddr == IDX_W'(i))
        empty_map[i] <= (wlen == '0);
    end
  end

endmodule

// File: rtl/idma_beat_seq.sv
module idma_beat_seq #(
  parameter int IDX_W   = 4,
  parameter int SIZE_W  = 16,
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [IDX_W:0]     cfg_entries,
  input  logic [FRAME_W-1:0] cfg_frames,
  input  logic [SIZE_W-1:0]  cur_len,
  output logic [IDX_W-1:0]   idx,
  output logic               chunk_end,
  output logic               frame_end,
  output logic               xfer_end
);
  logic [SIZE_W-1:0]  byte_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic [IDX_W:0]     entries_q;
  logic [FRAME_W-1:0] frames_q;

  assign chunk_end = (byte_cnt == cur_len - 1'b1);
  assign frame_end = chunk_end && ({1'b0, idx} == entries_q - 1'b1);
  assign xfer_end  = frame_end && (frame_cnt == frames_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt  <= '0;
      idx       <= '0;
      frame_cnt <= '0;
      entries_q <= '0;
      frames_q  <= '0;
    end else if (load) begin
      byte_cnt  <= '0;
      idx       <= '0;
      frame_cnt <= '0;
      entries_q <= cfg_entries;
      frames_q  <= cfg_frames;
    end else if (step) begin
      if (chunk_end) begin
        byte_cnt <= '0;
        if (frame_end) begin
          idx       <= '0;
          frame_cnt <= frame_cnt + 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    step |-> ({1'b0, idx} < entries_q)); // R5

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
    step |-> (frame_cnt < frames_q)); // R7

endmodule

// File: rtl/idma_addr_lane.sv
module idma_addr_lane #(
  parameter int ADDR_W = 32,
  parameter int GAP_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              inc,
  input  logic              scat,
  input  logic              step,
  input  logic              chunk_end,
  input  logic [GAP_W-1:0]  gap,
  output logic [ADDR_W-1:0] addr
);
  logic inc_q;
  logic scat_q;
  logic [ADDR_W-1:0] skip;

  assign skip = (scat_q && chunk_end) ? ADDR_W'(gap) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      inc_q  <= 1'b0;
      scat_q <= 1'b0;
    end else if (load) begin
      addr   <= base;
      inc_q  <= inc;
      scat_q <= scat;
    end else if (step && inc_q) begin
      addr <= addr + 1'b1 + skip;
    end
  end

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (step && !inc_q && !load) |=> $stable(addr)); // R4

  AST_CONTIG_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && inc_q && !scat_q && !load) |=> (addr == $past(addr) + 1'b1)); // R3

endmodule

// File: rtl/idma_addr_gen.sv
module idma_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int GAP_W     = 16,
  parameter int FRAME_W   = 16,
  parameter int TBL_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tbl_we,
  input  logic [$clog2(TBL_DEPTH)-1:0] tbl_waddr,
  input  logic [SIZE_W-1:0]            tbl_len,
  input  logic [GAP_W-1:0]             tbl_gap,
  input  logic [FRAME_W-1:0]           cfg_frames,
  input  logic [$clog2(TBL_DEPTH):0]   cfg_entries,
  input  logic [2:0]                   cfg_dir,
  input  logic                         cfg_src_inc,
  input  logic                         cfg_dst_inc,
  input  logic                         cfg_src_scat,
  input  logic                         cfg_dst_scat,
  input  logic [ADDR_W-1:0]            cfg_src_base,
  input  logic [ADDR_W-1:0]            cfg_dst_base,
  input  logic                         start,
  input  logic                         beat_ready,
  output logic                         beat_valid,
  output logic [ADDR_W-1:0]            beat_src,
  output logic [ADDR_W-1:0]            beat_dst,
  output logic                         beat_last,
  output logic                         frame_done,
  output logic                         done,
  output logic                         busy,
  output logic                         err
);
  import idma_pkg::*;

  localparam int IDX_W = $clog2(TBL_DEPTH);
  localparam int LEN_W = IDX_W + 1;

  logic [IDX_W-1:0]     rd_idx;
  logic [SIZE_W-1:0]    cur_len;
  logic [GAP_W-1:0]     cur_gap;
  logic [TBL_DEPTH-1:0] empty_map;
  logic                 chunk_end, frame_end, xfer_end;
  logic                 busy_q, done_q, fdone_q, err_q;
  logic                 start_ok, cfg_bad, used_empty, launch, step;

  idma_chunk_tbl #(
    .DEPTH (TBL_DEPTH),
    .SIZE_W(SIZE_W),
    .GAP_W (GAP_W)
  ) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .we       (tbl_we),
    .waddr    (tbl_waddr),
    .wlen     (tbl_len),
    .wgap     (tbl_gap),
    .raddr    (rd_idx),
    .rlen     (cur_len),
    .rgap     (cur_gap),
    .empty_map(empty_map)
  );

  always_comb begin
    used_empty = 1'b0;
    for (int i = 0; i < TBL_DEPTH; i++)
      if (LEN_W'(i) < cfg_entries && empty_map[i]) used_empty = 1'b1;
  end

  assign cfg_bad  = !dir_is_valid(cfg_dir) || (cfg_frames == '0) ||
                    (cfg_entries == '0) || (cfg_entries > LEN_W'(TBL_DEPTH)) ||
                    used_empty;
  assign start_ok = start && !busy_q;
  assign launch   = start_ok && !cfg_bad;
  assign step     = busy_q && beat_ready;

  idma_beat_seq #(
    .IDX_W  (IDX_W),
    .SIZE_W (SIZE_W),
    .FRAME_W(FRAME_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .load       (launch),
    .step       (step),
    .cfg_entries(cfg_entries),
    .cfg_frames (cfg_frames),
    .cur_len    (cur_len),
    .idx        (rd_idx),
    .chunk_end  (chunk_end),
    .frame_end  (frame_end),
    .xfer_end   (xfer_end)
  );

  logic [ADDR_W-1:0] lane_base [NUM_SIDES];
  logic              lane_inc  [NUM_SIDES];
  logic              lane_scat [NUM_SIDES];
  logic [ADDR_W-1:0] lane_addr [NUM_SIDES];

  assign lane_base[SIDE_SRC] = cfg_src_base;
  assign lane_base[SIDE_DST] = cfg_dst_base;
  assign lane_inc[SIDE_SRC]  = cfg_src_inc;
  assign lane_inc[SIDE_DST]  = cfg_dst_inc;
  assign lane_scat[SIDE_SRC] = cfg_src_scat;
  assign lane_scat[SIDE_DST] = cfg_dst_scat;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_lane
    idma_addr_lane #(
      .ADDR_W(ADDR_W),
      .GAP_W (GAP_W)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (launch),
      .base     (lane_base[s]),
      .inc      (lane_inc[s]),
      .scat     (lane_scat[s]),
      .step     (step),
      .chunk_end(chunk_end),
      .gap      (cur_gap),
      .addr     (lane_addr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fdone_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fdone_q <= 1'b0;
      if (start_ok) begin
        if (cfg_bad) begin
          err_q <= 1'b1;
        end else begin
          err_q  <= 1'b0;
          busy_q <= 1'b1;
        end
      end else if (step) begin
        if (frame_end) fdone_q <= 1'b1;
        if (xfer_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign beat_valid = busy_q;
  assign beat_src   = lane_addr[SIDE_SRC];
  assign beat_dst   = lane_addr[SIDE_DST];
  assign beat_last  = busy_q && xfer_end;
  assign frame_done = fdone_q;
  assign done       = done_q;
  assign busy       = busy_q;
  assign err        = err_q;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst))); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(beat_valid && beat_ready && beat_last)); // R8

  AST_DONE_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
    done |-> (frame_done && !busy)); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    err |-> !beat_valid); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(beat_ready && beat_last)) |=> busy); // R11

endmodule

// File: tb/idma_addr_gen_tb.sv
module idma_addr_gen_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_waddr = '0;
  logic [15:0] tbl_len = '0;
  logic [15:0] tbl_gap = '0;
  logic [15:0] cfg_frames = '0;
  logic [4:0]  cfg_entries = '0;
  logic [2:0]  cfg_dir = '0;
  logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic        cfg_src_scat = 1'b0, cfg_dst_scat = 1'b0;
  logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic        start = 1'b0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, beat_last, frame_done, done, busy, err;
  logic [31:0] beat_src, beat_dst;

  int checks = 0;
  int fails  = 0;
  int bl [DEPTH];
  int bg [DEPTH];

  always #5 clk = ~clk;

  idma_addr_gen u_dut (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_len(tbl_len), .tbl_gap(tbl_gap), .cfg_frames(cfg_frames),
    .cfg_entries(cfg_entries), .cfg_dir(cfg_dir),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_src_scat(cfg_src_scat), .cfg_dst_scat(cfg_dst_scat),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .start(start), .beat_ready(beat_ready), .beat_valid(beat_valid),
    .beat_src(beat_src), .beat_dst(beat_dst), .beat_last(beat_last),
    .frame_done(frame_done), .done(done), .busy(busy), .err(err)
  );

  // {src_inc, dst_inc, src_scat, dst_scat, dir[2:0], frames[3:0], entries[4:0], ready_mode[1:0]}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 4'd1, 5'd3,  2'd0},
    {1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 4'd2, 5'd2,  2'd1},
    {1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 4'd2, 5'd4,  2'd2},
    {1'b1, 1'b0, 1'b1, 1'b1, 3'd3, 4'd3, 5'd1,  2'd0},
    {1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 4'd2, 5'd16, 2'd1},
    {1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 4'd1, 5'd2,  2'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic wr_entry(input int i, input int len, input int gap);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 4'(i); tbl_len = 16'(len); tbl_gap = 16'(gap);
    @(negedge clk);
    tbl_we = 1'b0;
    bl[i] = len; bg[i] = gap;
  endtask

  task automatic set_cfg(input bit si, input bit di, input bit ss, input bit ds,
                         input int dir, input int fr, input int ent,
                         input logic [31:0] sb, input logic [31:0] db);
    cfg_src_inc = si; cfg_dst_inc = di; cfg_src_scat = ss; cfg_dst_scat = ds;
    cfg_dir = 3'(dir); cfg_frames = 16'(fr); cfg_entries = 5'(ent);
    cfg_src_base = sb; cfg_dst_base = db;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // drives one transfer from the current configuration and checks every beat
  task automatic run_xfer(input int mode, input bit poke, input string tag);
    longint es, ed, exp_total, seen;
    int bi, ci, fi, fcount, guard;
    bit seen_done, stalled, rdy;
    logic [31:0] hs, hd;
    bit si, di, ss, ds;
    int fr, ent;
    si = cfg_src_inc; di = cfg_dst_inc; ss = cfg_src_scat; ds = cfg_dst_scat;
    fr = int'(cfg_frames); ent = int'(cfg_entries);
    es = cfg_src_base; ed = cfg_dst_base;
    bi = 0; ci = 0; fi = 0; fcount = 0; guard = 0; seen = 0;
    seen_done = 0; stalled = 0; hs = '0; hd = '0;
    exp_total = 0;
    for (int i = 0; i < ent; i++) exp_total += bl[i];
    exp_total *= fr;
    kick();
    chk(err == 1'b0, "R12", {tag, " err after good start"}, err, 0);
    chk(busy == 1'b1, "R8", {tag, " busy after start"}, busy, 1);
    while (!seen_done && guard < 4000) begin
      if (frame_done) fcount++;
      if (done) begin
        seen_done = 1;
        chk(frame_done == 1'b1, "R8", {tag, " frame_done with done"}, frame_done, 1);
        chk(busy == 1'b0, "R8", {tag, " busy falls with done"}, busy, 0);
        chk(seen == exp_total, "R8", {tag, " beats before done"}, seen, exp_total);
      end
      if (stalled) begin
        chk(beat_valid && beat_src == hs && beat_dst == hd, "R6", {tag, " hold on stall"},
            beat_src, hs);
      end
      if (poke && guard == 3) begin
        start = 1'b0;
        chk(busy == 1'b1 && longint'(beat_src) == es, "R11", {tag, " start while busy"},
            beat_src, es);
      end
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (guard % 2) == 0;
        default: rdy = (guard % 3) == 2;
      endcase
      beat_ready = rdy;
      if (beat_valid && rdy) begin
        bit fin, cend;
        cend = (bi == bl[ci] - 1);
        fin  = cend && (ci == ent - 1) && (fi == fr - 1);
        chk(longint'(beat_src) == es, si ? (ss ? "R5" : "R3") : "R4",
            {tag, " src"}, beat_src, es);
        chk(longint'(beat_dst) == ed, di ? (ds ? "R5" : "R3") : "R4",
            {tag, " dst"}, beat_dst, ed);
        chk(beat_last == fin, "R7", {tag, " last flag"}, beat_last, fin);
        seen++;
        if (cend) begin
          if (si) es += 1 + (ss ? bg[ci] : 0);
          if (di) ed += 1 + (ds ? bg[ci] : 0);
          bi = 0;
          if (ci == ent - 1) begin ci = 0; fi++; end
          else ci++;
        end else begin
          if (si) es += 1;
          if (di) ed += 1;
          bi++;
        end
      end
      stalled = beat_valid && !rdy;
      hs = beat_src; hd = beat_dst;
      if (poke && guard == 2) begin
        start = 1'b1;
        cfg_src_base = 32'hDEAD_0000;
      end
      @(negedge clk);
      guard++;
    end
    beat_ready = 1'b0;
    chk(seen_done, "R8", {tag, " done seen"}, seen_done, 1);
    chk(fcount == fr, "R8", {tag, " frame_done count"}, fcount, fr);
  endtask

  task automatic try_bad(input string req, input string what);
    kick();
    chk(err == 1'b1, req, {what, " err"}, err, 1);
    chk(busy == 1'b0 && beat_valid == 1'b0, req, {what, " no beats"}, beat_valid, 0);
    repeat (3) @(negedge clk);
    chk(beat_valid == 1'b0 && done == 1'b0, req, {what, " stays idle"}, beat_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual busy expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin bl[i] = 0; bg[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!beat_valid && !beat_last && !busy && !frame_done && !done && !err,
        "R1", "outputs after reset", {beat_valid, beat_last, busy, frame_done, done, err}, 0);

    // R10 unwritten entries count as zero length
    set_cfg(1, 1, 0, 0, 0, 1, 1, 32'h100, 32'h200);
    try_bad("R10", "unwritten table");

    for (int i = 0; i < DEPTH; i++) wr_entry(i, (i % 3) + 1, 4 * i + 3);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic [17:0] w;
      w = VEC[v];
      set_cfg(w[17], w[16], w[15], w[14], int'(w[13:11]), int'(w[10:7]), int'(w[6:2]),
              32'h1000 * (v + 1), 32'h8000_0000 + 32'h100 * v);
      run_xfer(int'(w[1:0]), v == 2, $sformatf("vec%0d", v));
    end

    // R2 table retained: rerun vector 1 shape with new bases only
    set_cfg(1, 1, 1, 0, 1, 2, 2, 32'h0005_0000, 32'h0006_0000);
    run_xfer(0, 0, "R2 retained table");

    // R9 direction code rejection
    set_cfg(1, 1, 0, 0, 4, 1, 2, 32'h10, 32'h20);
    try_bad("R9", "dir code 4");
    set_cfg(1, 1, 0, 0, 7, 1, 2, 32'h10, 32'h20);
    try_bad("R9", "dir code 7");

    // R12 err cleared by a good start (checked inside run_xfer)
    set_cfg(1, 1, 1, 1, 3, 1, 2, 32'h300, 32'h400);
    run_xfer(1, 0, "R12 recover");

    // R10 bad counts
    set_cfg(1, 1, 0, 0, 0, 1, 0, 32'h10, 32'h20);
    try_bad("R10", "zero entries");
    set_cfg(1, 1, 0, 0, 0, 0, 2, 32'h10, 32'h20);
    try_bad("R10", "zero frames");
    set_cfg(1, 1, 0, 0, 0, 1, 17, 32'h10, 32'h20);
    try_bad("R10", "entries above depth");

    // R2 overwrite entry 0 with a longer chunk
    wr_entry(0, 5, 9);
    set_cfg(1, 1, 1, 1, 2, 2, 1, 32'h700, 32'h900);
    run_xfer(0, 0, "R2 rewritten entry");

    // R10 zero length inside the used range only
    wr_entry(2, 0, 1);
    set_cfg(1, 1, 0, 0, 0, 1, 3, 32'h10, 32'h20);
    try_bad("R10", "zero chunk used");
    set_cfg(1, 1, 1, 1, 0, 1, 2, 32'hA00, 32'hB00);
    run_xfer(2, 0, "R10 zero chunk beyond range");

    summary();
    $finish;
  end

endmodule